// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses which of up to fourteen peripheral interrupt sources, or a software trap, a small 8-bit CPU services next. Each source owns a 2-bit software level held in a bank of byte-wide level registers that software writes. The CPU presents its current 2-bit mask level. This is the pair formed by condition-code bit 5 (upper) and bit 3 (lower). At the end of every instruction the CPU pulses a boundary strobe, and the controller decides on that strobe alone.

When a request wins, the controller pulses a take signal and presents the entry address of a fixed two-byte vector slot in the FFE0h–FFFFh table. It also presents the level the CPU must load into its mask bits. A source raises the mask to its own software level, so only strictly higher levels can interrupt its handler, and nesting happens by level. Each take pushes the old mask level onto a four-entry level stack. A return-from-interrupt strobe pops that stack and hands the saved level back to the CPU, so the interrupted level resumes. Register stacking to memory and instruction fetch belong to the CPU.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is held and after its release, take_o and the flag outputs are 0, vector_o is FFFEh and lvl_o is 3.
- R2: A take happens only for an instr_end strobe. take_o is a one-cycle pulse in the cycle after the strobe, and vector_o and lvl_o change in that same cycle.
- R3: A maskable source is eligible only when its request is high and its software level is strictly greater than lvl_in. A level of 0 never wins, and lvl_in = 3 blocks every maskable source.
- R4: Among eligible sources the highest software level wins. On equal levels the lower source index wins.
- R5: Source i is served at vector FFFAh − 2·i, and the trap at FFFCh. FFFEh is the reset slot, and every vector lies in FFE0h–FFFFh at an even address.
- R6: On a maskable take, lvl_o becomes the winning source's software level.
- R7: trap_req with instr_end is taken whatever lvl_in is, in preference to every maskable source, and sets lvl_o to 3.
- R8: A write with prio_we stores prio_wdata into level register prio_addr. Bits 2j+1:2j of register k hold the level of source 4k+j. Every level resets to 3.
- R9: On iret with a non-empty stack, lvl_restore_o pulses in the next cycle and lvl_o takes the most recently pushed level. Levels come back in last-in, first-out order.
- R10: A take when the stack holds 4 levels still takes place but stores nothing, and stk_ovf_o pulses. The stored levels are left intact.
- R11: iret on an empty stack pulses stk_unf_o, gives no lvl_restore_o pulse, and leaves lvl_o unchanged.
- R12: When iret and instr_end arrive in the same cycle, only the return is acted on and no take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 14 | Request line per source; index 0 has the highest hardware order |
| trap_req | input | 1 | Software trap, non-maskable |
| prio_we | input | 1 | Level register write enable |
| prio_addr | input | 2 | Level register index |
| prio_wdata | input | 8 | Four 2-bit level fields |
| lvl_in | input | 2 | Current CPU mask level: bit 1 = CC bit 5, bit 0 = CC bit 3 |
| instr_end | input | 1 | Instruction-boundary strobe |
| iret | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Interrupt taken pulse |
| vector_o | output | 16 | Vector slot address of the last take |
| lvl_o | output | 2 | Mask level for the CPU to load |
| lvl_restore_o | output | 1 | Pulse: lvl_o holds a level popped from the stack |
| stk_ovf_o | output | 1 | Pulse: take with a full stack |
| stk_unf_o | output | 1 | Pulse: return with an empty stack |

## Verification
Several properties are checked on every cycle: a take always follows a boundary strobe and never follows a return, and a take always lands on an even address inside the table. A maskable take always raises the level above the old mask, and a trap take always yields FFFCh with level 3. The stack count never passes its depth, and a restore never coincides with a take. Only the bench's scenarios can show which source wins for a given mix of levels and mask, which register field belongs to which source, and that nested returns give back the saved levels in the right order after an overflow.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;
  localparam int REG_W = 8;
  localparam int MAX_SRC = 14;
  localparam logic [15:0] RESET_VEC   = 16'hFFFE;
  localparam logic [15:0] TRAP_VEC    = 16'hFFFC;
  localparam logic [15:0] SRC_VEC_TOP = 16'hFFFA;
endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int ADDR_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl
);
  localparam int FPR = REG_W / LVL_W;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lvl_t lvl_q, lvl_d;
    logic hit;

    assign hit = we && (addr == ADDR_W'(g / FPR));

    always_comb begin
      lvl_d = lvl_q;
      if (hit) lvl_d = wdata[(g % FPR)*LVL_W +: LVL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= LVL_TOP;
      else if (hit) lvl_q <= lvl_d;
    end

    assign src_lvl[g] = lvl_q;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
  input  lvl_t                          mask,
  output logic                          hit,
  output logic [IDX_W-1:0]              win_idx,
  output lvl_t                          win_lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = req[g] && (src_lvl[g] > mask);
  end

  // Scan upward: a later index replaces the current pick only on a
  // strictly higher level, so ties stay with the lower index.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!hit || (src_lvl[i] > win_lvl))) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic pop_ok,
  output lvl_t pop_lvl,
  output logic ovf,
  output logic unf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, push_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && !pop && !full;
  assign ovf     = push && !pop && full;
  assign unf     = pop && empty;
  assign pop_lvl = mem[PTR_W'(cnt_q - 1'b1)];

  always_comb begin
    cnt_d = cnt_q;
    if (pop_ok)       cnt_d = cnt_q - 1'b1;
    else if (push_ok) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (pop_ok || push_ok)  cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[PTR_W'(cnt_q)] <= push_lvl;
  end

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (cnt_q == CNT_W'(DEPTH)));
  a_r11_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (cnt_q == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC   = 14,
  parameter int STK_DEPTH = 4,
  parameter int ADDR_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               trap_req,
  input  logic               prio_we,
  input  logic [ADDR_W-1:0]  prio_addr,
  input  logic [7:0]         prio_wdata,
  input  logic [1:0]         lvl_in,
  input  logic               instr_end,
  input  logic               iret,
  output logic               take_o,
  output logic [15:0]        vector_o,
  output logic [1:0]         lvl_o,
  output logic               lvl_restore_o,
  output logic               stk_ovf_o,
  output logic               stk_unf_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic                          arb_hit;
  logic [IDX_W-1:0]              win_idx;
  lvl_t                          win_lvl;
  logic                          take_now, pop_ok, ovf, unf;
  lvl_t                          pop_lvl;

  nic_prio_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(prio_we), .addr(prio_addr),
    .wdata(prio_wdata), .src_lvl(src_lvl)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req(irq_req), .src_lvl(src_lvl), .mask(lvl_in),
    .hit(arb_hit), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // A return in the same cycle as a boundary takes precedence.
  assign take_now = instr_end && !iret && (trap_req || arb_hit);

  nic_level_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_s), .push(take_now), .push_lvl(lvl_in),
    .pop(iret), .pop_ok(pop_ok), .pop_lvl(pop_lvl), .ovf(ovf), .unf(unf)
  );

  logic        take_q, take_d;
  logic [15:0] vec_q, vec_d;
  lvl_t        lvl_q, lvl_d;
  logic        rest_q, rest_d;
  logic        ovf_q, ovf_d;
  logic        unf_q, unf_d;

  always_comb begin
    take_d = take_now;
    rest_d = pop_ok;
    ovf_d  = ovf;
    unf_d  = unf;
    vec_d  = vec_q;
    lvl_d  = lvl_q;
    if (take_now) begin
      if (trap_req) begin
        vec_d = TRAP_VEC;
        lvl_d = LVL_TOP;
      end else begin
        vec_d = SRC_VEC_TOP - 16'({win_idx, 1'b0});
        lvl_d = win_lvl;
      end
    end else if (pop_ok) begin
      lvl_d = pop_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      take_q <= 1'b0;
      rest_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      vec_q  <= RESET_VEC;
      lvl_q  <= LVL_TOP;
    end else begin
      take_q <= take_d;
      rest_q <= rest_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      if (take_now || pop_ok) begin
        vec_q <= vec_d;
        lvl_q <= lvl_d;
      end
    end
  end

  assign take_o        = take_q;
  assign vector_o      = vec_q;
  assign lvl_o         = lvl_q;
  assign lvl_restore_o = rest_q;
  assign stk_ovf_o     = ovf_q;
  assign stk_unf_o     = unf_q;

  a_r2_take_on_boundary: assert property (@(posedge clk) disable iff (!rst_s)
    take_o |-> $past(instr_end));
  a_r12_return_first: assert property (@(posedge clk) disable iff (!rst_s)
    take_o |-> !$past(iret));
  a_r5_vec_in_table: assert property (@(posedge clk) disable iff (!rst_s)
    take_o |-> ((vector_o[15:5] == 11'h7FF) && !vector_o[0]));
  a_r3_level_rises: assert property (@(posedge clk) disable iff (!rst_s)
    (take_o && !$past(trap_req)) |-> (lvl_o > $past(lvl_in)));
  a_r7_trap_slot: assert property (@(posedge clk) disable iff (!rst_s)
    (take_o && $past(trap_req)) |-> ((vector_o == TRAP_VEC) && (lvl_o == LVL_TOP)));
  a_r9_restore_alone: assert property (@(posedge clk) disable iff (!rst_s)
    lvl_restore_o |-> (!take_o && !stk_unf_o));
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  localparam int NS = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_req;
  logic          trap_req, prio_we, instr_end, iret;
  logic [1:0]    prio_addr, lvl_in;
  logic [7:0]    prio_wdata;
  logic          take_o, lvl_restore_o, stk_ovf_o, stk_unf_o;
  logic [15:0]   vector_o;
  logic [1:0]    lvl_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int lv [NS];

  always #2 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
    .prio_we(prio_we), .prio_addr(prio_addr), .prio_wdata(prio_wdata),
    .lvl_in(lvl_in), .instr_end(instr_end), .iret(iret),
    .take_o(take_o), .vector_o(vector_o), .lvl_o(lvl_o),
    .lvl_restore_o(lvl_restore_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Write all level registers from the shadow copy (R8 field layout).
  task automatic wr_all();
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'h00;
      for (int j = 0; j < 4; j++)
        if (4*k + j < NS) d[2*j +: 2] = 2'(lv[4*k + j]);
      prio_we = 1'b1; prio_addr = 2'(k); prio_wdata = d;
      @(posedge clk); @(negedge clk);
    end
    prio_we = 1'b0;
  endtask

  task automatic strobe(input logic ie, input logic ir);
    instr_end = ie; iret = ir;
    @(posedge clk); @(negedge clk);
    instr_end = 1'b0; iret = 1'b0;
  endtask

  function automatic int vec_of(input int s);
    return 16'hFFFA - 2*s;
  endfunction

  // One take followed by a return that must restore mask m.
  task automatic serve(input string tag, input int m, input bit exp_take,
                       input int exp_vec, input int exp_lvl);
    lvl_in = 2'(m);
    strobe(1'b1, 1'b0);
    chk(tag, take_o, exp_take);
    irq_req = '0; trap_req = 1'b0;
    if (exp_take) begin
      chk(tag, vector_o, exp_vec);
      chk(tag, lvl_o, exp_lvl);
      strobe(1'b0, 1'b1);
      chk("R9 restore pulse", lvl_restore_o, 1);
      chk("R9 restored level", lvl_o, m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; trap_req = 1'b0; prio_we = 1'b0;
    prio_addr = '0; prio_wdata = '0; lvl_in = 2'd0; instr_end = 1'b0; iret = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 take in reset", take_o, 0);
    chk("R1 vector in reset", vector_o, 16'hFFFE);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 take", take_o, 0);
    chk("R1 vector", vector_o, 16'hFFFE);
    chk("R1 level", lvl_o, 3);
    chk("R1 flags", {lvl_restore_o, stk_ovf_o, stk_unf_o}, 0);

    // R8 reset level 3: source 7 wins over mask 2, blocked by mask 3 (R3).
    irq_req = '0; irq_req[7] = 1'b1;
    serve("R8 reset level", 2, 1'b1, vec_of(7), 3);
    irq_req[7] = 1'b1;
    serve("R3 mask 3 blocks", 3, 1'b0, 0, 0);

    // R2: pending request without a boundary never taken.
    irq_req = '0; irq_req[4] = 1'b1; lvl_in = 2'd0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R2 no boundary", take_o, 0);
    end
    irq_req = '0;

    // Single-source sweep: every source, level and mask (R3, R5, R6, R8).
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < 4; l++) begin
        for (int i = 0; i < NS; i++) lv[i] = 0;
        lv[s] = l;
        wr_all();
        for (int m = 0; m < 4; m++) begin
          irq_req = '0; irq_req[s] = 1'b1;
          serve("R3/R5/R6 single", m, l > m, vec_of(s), l);
        end
      end

    // Pair sweep at mask 0 (R4).
    for (int a = 0; a < NS; a++)
      for (int b = a + 1; b < NS; b++)
        for (int la = 1; la < 4; la++)
          for (int lb = 1; lb < 4; lb++) begin
            for (int i = 0; i < NS; i++) lv[i] = 0;
            lv[a] = la; lv[b] = lb;
            wr_all();
            irq_req = '0; irq_req[a] = 1'b1; irq_req[b] = 1'b1;
            if (lb > la) serve("R4 pair", 0, 1'b1, vec_of(b), lb);
            else         serve("R4 pair", 0, 1'b1, vec_of(a), la);
          end

    // R7: trap ignores mask 3 and beats a level-3 source.
    for (int i = 0; i < NS; i++) lv[i] = 3;
    wr_all();
    irq_req = '1; trap_req = 1'b1;
    serve("R7 trap mask 3", 3, 1'b1, 16'hFFFC, 3);
    irq_req = '1; trap_req = 1'b1;
    serve("R7 trap beats src", 0, 1'b1, 16'hFFFC, 3);

    // Nesting, overflow and underflow (R9, R10, R11).
    for (int i = 0; i < NS; i++) lv[i] = 0;
    lv[2] = 1; lv[5] = 2; lv[9] = 3;
    wr_all();
    irq_req = '0; irq_req[2] = 1'b1; lvl_in = 2'd0;
    strobe(1'b1, 1'b0);
    chk("R6 nest 1 vec", vector_o, vec_of(2)); chk("R6 nest 1 lvl", lvl_o, 1);
    irq_req[5] = 1'b1; lvl_in = 2'd1;
    strobe(1'b1, 1'b0);
    chk("R4 nest 2 vec", vector_o, vec_of(5)); chk("R6 nest 2 lvl", lvl_o, 2);
    irq_req[9] = 1'b1; lvl_in = 2'd2;
    strobe(1'b1, 1'b0);
    chk("R4 nest 3 vec", vector_o, vec_of(9)); chk("R6 nest 3 lvl", lvl_o, 3);
    irq_req = '0; trap_req = 1'b1; lvl_in = 2'd3;
    strobe(1'b1, 1'b0);
    chk("R7 nest trap", take_o, 1); chk("R10 no ovf at 4", stk_ovf_o, 0);
    strobe(1'b1, 1'b0);
    chk("R10 take when full", take_o, 1); chk("R10 ovf pulse", stk_ovf_o, 1);
    trap_req = 1'b0;
    for (int e = 3; e >= 0; e--) begin
      strobe(1'b0, 1'b1);
      chk("R9 LIFO pulse", lvl_restore_o, 1);
      chk("R10 LIFO level", lvl_o, e);
    end
    strobe(1'b0, 1'b1);
    chk("R11 unf pulse", stk_unf_o, 1);
    chk("R11 no restore", lvl_restore_o, 0);
    chk("R11 level kept", lvl_o, 0);

    // R12: return and boundary together.
    irq_req = '0; irq_req[9] = 1'b1; lvl_in = 2'd0;
    strobe(1'b1, 1'b0);
    chk("R12 setup take", take_o, 1);
    trap_req = 1'b1; lvl_in = 2'd3;
    strobe(1'b1, 1'b1);
    chk("R12 no take", take_o, 0);
    chk("R12 restore", lvl_restore_o, 1);
    chk("R12 level", lvl_o, 0);
    trap_req = 1'b0; irq_req = '0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule